// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that gives a bus host byte access to a bank of 8-bit registers. It watches SCL and SDA after a two-flop synchronizer on a fast system clock, finds start, repeated start and stop conditions, and compares the 7-bit device address with six fixed bits and one bit taken from a strap input. After an address with the write direction, the first byte loads a register pointer and each following byte is written to the register that the pointer selects. After an address with the read direction, bytes are shifted out MSB first from the pointer. The pointer advances after every data byte, and it keeps its value across a repeated start and across separate transfers.

The register file sits behind a simple port with a pointer output, a write strobe and data, and a read strobe with a read-data input that is sampled in the strobe cycle. A set of protected registers takes writes only while the run-mode input is low. Addresses outside the implemented set read as zero and discard writes, and every such byte is still acknowledged. SDA is driven open-drain: `sdaOe` high pulls the line low.

Top module: `i2c_reg_target`

## Requirements
- R1: The device address is `{ADDR_FIXED, addrStrap}`, with ADDR_FIXED defaulting to 6'b000111. An address byte whose upper seven bits do not match gets no ACK. The block then leaves SDA released and issues no strobes until the next start or stop.
- R2: A stop (SDA rising while SCL is high) always returns the block to idle, even in the middle of a byte. A start or repeated start (SDA falling while SCL is high) always begins a new address byte.
- R3: After a matched address byte, a pointer byte or a write data byte, the block holds SDA low through the whole high phase of the ninth clock and releases it after that clock falls.
- R4: The byte that follows a write-direction address is loaded into the pointer and appears on `regAddr`.
- R5: Each further write byte produces a one-cycle `regWrEn` with that byte on `regWrData` at the current pointer, and the pointer then advances by one.
- R6: A read-direction address starts transmission at the current pointer. The pointer is kept through a repeated start and between transfers. Each byte is sent MSB first, and `regRdEn` pulses for one cycle while `regRdData` is sampled.
- R7: While the host ACKs, the next byte (pointer plus one) is sent. After a NACK the block releases SDA and issues no further strobes until a start or stop.
- R8: While `runMode` is 1, writes to protected addresses (default 0x1B, 0x1D, 0x1E, 0x1F, 0x21, 0x29, 0x6A) give no `regWrEn`. These bytes are still ACKed and the pointer still advances.
- R9: An address outside the implemented set (default 0x06–0x0C, 0x0F, 0x16–0x18, 0x1A, 0x1B, 0x1D–0x1F, 0x21, 0x29, 0x3A, 0x6A) reads as 0x00 without `regRdEn`. A write to it is ACKed and dropped without `regWrEn`. The pointer advances in both cases.
- R10: `sdaOe` changes only while the synchronized SCL is low, except around a start or stop.
- R11: In reset and while idle, `sdaOe`, `regWrEn` and `regRdEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| addrStrap | input | 1 | Selects the device address LSB |
| runMode | input | 1 | Run-mode bit; 1 blocks protected writes |
| regAddr | output | 8 | Register pointer |
| regWrEn | output | 1 | Register write strobe |
| regWrData | output | 8 | Register write data |
| regRdEn | output | 1 | Register read strobe |
| regRdData | input | 8 | Register read data, sampled with regRdEn |

## Verification
The assertions check on every cycle that the ACK is held through the acknowledge states, that SDA stays quiet after a mismatch and only moves while SCL is low, and that a stop always lands in idle. They also check that the pointer loads from the received byte and steps after every data byte, blocked or not, that reserved reads put a zero MSB on the line, and that the two strobes never fire together. Only the bench scenarios can show the behaviour of whole transfers: the byte values read back across a repeated start, continuation after a transfer has ended, run-mode gating of a burst that crosses reserved and protected addresses, and recovery after a stop in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int NUM_REGS = 256;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SKIP, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic doWrite;
    logic doRead;
    logic shiftOut;
  } dpCmd_t;

  function automatic logic [NUM_REGS-1:0] defaultImplMask();
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) begin
      m[i] = (i >= 6 && i <= 12) || i == 15 || (i >= 22 && i <= 24) ||
             i == 26 || i == 27 || (i >= 29 && i <= 31) || i == 33 ||
             i == 41 || i == 58 || i == 106;
    end
    return m;
  endfunction

  function automatic logic [NUM_REGS-1:0] defaultProtMask();
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) begin
      m[i] = i == 27 || (i >= 29 && i <= 31) || i == 33 || i == 41 || i == 106;
    end
    return m;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[0] <= '1;
        else       pipe[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= '1;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [6:0] devAddr,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpCmd_t     cmd,
  output logic       sdaOe
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  tgtState_t  st, stN;
  logic [3:0] cnt, cntN;
  logic       ackDrive, ackN, rdMode, rdN, hostAck, hAckN;
  logic       sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet, stopDet;

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ackDrive <= 1'b0;
      rdMode   <= 1'b0;
      hostAck  <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      st       <= stN;
      cnt      <= cntN;
      ackDrive <= ackN;
      rdMode   <= rdN;
      hostAck  <= hAckN;
      sclPrev  <= sclS;
      sdaPrev  <= sdaS;
    end
  end

  assign sdaOe = ackDrive | ((st == ST_RDAT) & ~txMsb);

  always_comb begin
    cmd   = '0;
    stN   = st;
    cntN  = cnt;
    ackN  = ackDrive;
    rdN   = rdMode;
    hAckN = hostAck;
    if (stopDet) begin
      stN  = ST_IDLE;
      ackN = 1'b0;
      cntN = '0;
    end else if (startDet) begin
      stN  = ST_ADDR;
      ackN = 1'b0;
      cntN = '0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (sclRise && cnt < BITS_PER_BYTE) begin
            cmd.shiftIn = 1'b1;
            cntN        = cnt + 4'd1;
          end else if (sclFall && cnt == BITS_PER_BYTE) begin
            cntN = '0;
            if (st == ST_ADDR) begin
              if (rxByte[7:1] == devAddr) begin
                ackN = 1'b1;
                rdN  = rxByte[0];
                stN  = ST_AACK;
              end else begin
                stN = ST_SKIP;
              end
            end else if (st == ST_PTR) begin
              cmd.loadPtr = 1'b1;
              ackN        = 1'b1;
              stN         = ST_PACK;
            end else begin
              cmd.doWrite = 1'b1;
              ackN        = 1'b1;
              stN         = ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            ackN = 1'b0;
            cntN = '0;
            if (rdMode) begin
              cmd.doRead = 1'b1;
              stN        = ST_RDAT;
            end else begin
              stN = ST_PTR;
            end
          end
        end
        ST_PACK, ST_WACK: begin
          if (sclFall) begin
            ackN = 1'b0;
            cntN = '0;
            stN  = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (sclRise) begin
            cntN = cnt + 4'd1;
          end else if (sclFall) begin
            if (cnt == BITS_PER_BYTE) begin
              cntN = '0;
              stN  = ST_RACK;
            end else begin
              cmd.shiftOut = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            hAckN = ~sdaS;
          end else if (sclFall) begin
            if (hostAck) begin
              cmd.doRead = 1'b1;
              stN        = ST_RDAT;
            end else begin
              stN = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> st == ST_IDLE);

  assert_skip_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SKIP) |-> !sdaOe);

  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_AACK || st == ST_PACK || st == ST_WACK) |-> sdaOe);

  assert_scl_high_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter logic [NUM_REGS-1:0] IMPL_MASK = defaultImplMask(),
  parameter logic [NUM_REGS-1:0] PROT_MASK = defaultProtMask()
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaS,
  input  dpCmd_t     cmd,
  input  logic       runMode,
  input  logic [7:0] regRdData,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic [7:0] regAddr,
  output logic       regWrEn,
  output logic [7:0] regWrData,
  output logic       regRdEn
);
  logic [7:0] rxSr, txSr, ptr;
  logic       ptrImpl, ptrProt, wrAllowed;

  assign ptrImpl   = IMPL_MASK[ptr];
  assign ptrProt   = PROT_MASK[ptr];
  assign wrAllowed = ptrImpl & ~(runMode & ptrProt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr <= '0;
      txSr <= '1;
      ptr  <= '0;
    end else begin
      if (cmd.shiftIn) rxSr <= {rxSr[6:0], sdaS};
      if (cmd.loadPtr) ptr <= rxSr;
      else if (cmd.doWrite || cmd.doRead) ptr <= ptr + 8'd1;
      if (cmd.doRead) txSr <= ptrImpl ? regRdData : 8'h00;
      else if (cmd.shiftOut) txSr <= {txSr[6:0], 1'b1};
    end
  end

  assign rxByte    = rxSr;
  assign txMsb     = txSr[7];
  assign regAddr   = ptr;
  assign regWrData = rxSr;
  assign regWrEn   = cmd.doWrite & wrAllowed;
  assign regRdEn   = cmd.doRead & ptrImpl;

  assert_ptr_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadPtr |=> regAddr == $past(rxByte));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regAddr == $past(regAddr) + 8'd1);

  assert_blocked_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.doWrite && !regWrEn) |=> regAddr == $past(regAddr) + 8'd1);

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.doRead && !regRdEn) |=> !txMsb);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, regRdEn}));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [5:0]          ADDR_FIXED  = 6'b000111,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [NUM_REGS-1:0] IMPL_MASK   = defaultImplMask(),
  parameter logic [NUM_REGS-1:0] PROT_MASK   = defaultProtMask()
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       addrStrap,
  input  logic       runMode,
  output logic [7:0] regAddr,
  output logic       regWrEn,
  output logic [7:0] regWrData,
  output logic       regRdEn,
  input  logic [7:0] regRdData
);
  logic [1:0] busSync;
  logic       sclS, sdaS, txMsb;
  logic [7:0] rxByte;
  logic [6:0] devAddr;
  dpCmd_t     cmd;

  assign devAddr = {ADDR_FIXED, addrStrap};

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout(busSync));

  assign sclS = busSync[1];
  assign sdaS = busSync[0];

  i2c_tgt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .devAddr(devAddr),
    .rxByte(rxByte), .txMsb(txMsb), .cmd(cmd), .sdaOe(sdaOe));

  i2c_tgt_dp #(.IMPL_MASK(IMPL_MASK), .PROT_MASK(PROT_MASK)) dp_i (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .cmd(cmd), .runMode(runMode),
    .regRdData(regRdData), .rxByte(rxByte), .txMsb(txMsb), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn));

endmodule

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic addrStrap = 1'b0, runMode = 1'b0;
  logic sdaOe, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sda;
  logic [7:0] mem [256];

  int total = 0, bad = 0, rdCount = 0;
  bit done = 0;

  typedef struct { logic [7:0] a; logic [7:0] d; } wrItem_t;
  wrItem_t expQ[$];

  always #2 clk = ~clk;

  assign sda = sdaDrv & ~sdaOe;
  assign regRdData = mem[regAddr];

  i2c_reg_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sda), .sdaOe(sdaOe),
    .addrStrap(addrStrap), .runMode(runMode), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData));

  // register file model behind the target
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (regWrEn) begin
      mem[regAddr] <= regWrData;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && regRdEn) rdCount++;
    if (rstN && regWrEn) begin
      if (expQ.size() == 0) begin
        check("R5/R8 unexpected write", {regAddr, regWrData}, 16'hxxxx);
      end else begin
        wrItem_t e;
        e = expQ.pop_front();
        check("R5 write", {regAddr, regWrData}, {e.a, e.d});
      end
    end
  end

  task automatic expWr(input logic [7:0] a, input logic [7:0] d);
    wrItem_t e;
    e.a = a; e.d = d;
    expQ.push_back(e);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart;
    sdaDrv = 1'b1; waitN(Q); sclDrv = 1'b1; waitN(2*Q);
    sdaDrv = 1'b0; waitN(2*Q); sclDrv = 1'b0; waitN(Q);
  endtask

  task automatic doStop;
    sdaDrv = 1'b0; waitN(Q); sclDrv = 1'b1; waitN(2*Q);
    sdaDrv = 1'b1; waitN(2*Q);
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; waitN(Q); sclDrv = 1'b1; waitN(2*Q); sclDrv = 1'b0; waitN(Q);
  endtask

  task automatic recvBit(output logic early, output logic late);
    sdaDrv = 1'b1; waitN(Q); sclDrv = 1'b1; waitN(2);
    early = sda; waitN(2*Q-2); late = sda;
    sclDrv = 1'b0; waitN(Q);
  endtask

  // returns {early,late} of the ninth clock: 00 = ACK held, 11 = NACK
  task automatic txByte(input logic [7:0] d, output logic [1:0] ackBits);
    logic e, l;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(e, l);
    ackBits = {e, l};
  endtask

  task automatic rxByte(output logic [7:0] d, input logic hostAck);
    logic e, l;
    for (int i = 7; i >= 0; i--) begin
      recvBit(e, l);
      d[i] = l;
    end
    sendBit(~hostAck);
  endtask

  logic [1:0] ak;
  logic [7:0] rd;
  int rdBase;

  initial begin
    waitN(20);
    check("R11 reset sdaOe", sdaOe, 0);
    check("R11 reset wr", regWrEn, 0);
    check("R11 reset rd", regRdEn, 0);
    rstN = 1'b1;
    waitN(20);
    check("R11 idle sdaOe", sdaOe, 0);

    // burst write, strap 0: device byte 0x1C/0x1D
    expWr(8'h1D, 8'h11); expWr(8'h1E, 8'h22); expWr(8'h1F, 8'h33);
    doStart;
    txByte(8'h1C, ak); check("R1 addr ack", ak, 2'b00);
    txByte(8'h1D, ak); check("R4 ptr ack R3", ak, 2'b00);
    txByte(8'h11, ak); check("R3 data ack", ak, 2'b00);
    txByte(8'h22, ak); check("R3 data ack", ak, 2'b00);
    txByte(8'h33, ak); check("R3 data ack", ak, 2'b00);
    doStop; waitN(10);
    check("R5 all writes seen", expQ.size(), 0);

    // read back across repeated start
    rdBase = rdCount;
    doStart; txByte(8'h1C, ak); txByte(8'h1D, ak);
    doStart; txByte(8'h1D, ak); check("R6 read addr ack", ak, 2'b00);
    rxByte(rd, 1'b1); check("R6 rd 1D", rd, 8'h11);
    rxByte(rd, 1'b1); check("R7 rd 1E", rd, 8'h22);
    rxByte(rd, 1'b0); check("R7 rd 1F", rd, 8'h33);
    doStop; waitN(10);
    check("R7 read strobes", rdCount - rdBase, 3);

    // pointer kept between transfers: now at reserved 0x20
    rdBase = rdCount;
    doStart; txByte(8'h1D, ak);
    rxByte(rd, 1'b0); check("R6 R9 continue at 0x20", rd, 8'h00);
    doStop; waitN(10);
    check("R9 no strobe reserved", rdCount - rdBase, 0);

    // mismatched address is ignored
    doStart;
    txByte(8'h1E, ak); check("R1 mismatch nack", ak, 2'b11);
    txByte(8'h1D, ak); check("R1 ignored byte", ak, 2'b11);
    txByte(8'h99, ak); check("R1 ignored byte", ak, 2'b11);
    doStop; waitN(10);

    // strap high selects 0x0F
    addrStrap = 1'b1;
    expWr(8'h3A, 8'hCA);
    doStart;
    txByte(8'h1E, ak); check("R1 strap addr ack", ak, 2'b00);
    txByte(8'h3A, ak);
    txByte(8'hCA, ak); check("R3 ack", ak, 2'b00);
    doStop; waitN(10);
    check("R5 write 3A", expQ.size(), 0);

    // run mode blocks protected writes
    runMode = 1'b1;
    expWr(8'h1A, 8'h12);
    doStart; txByte(8'h1E, ak); txByte(8'h1A, ak);
    txByte(8'h12, ak);
    txByte(8'h34, ak); check("R8 blocked ack", ak, 2'b00);
    txByte(8'h56, ak); check("R9 reserved ack", ak, 2'b00);
    txByte(8'h78, ak); check("R8 blocked ack", ak, 2'b00);
    doStop; waitN(10);
    runMode = 1'b0;
    rdBase = rdCount;
    doStart; txByte(8'h1E, ak); txByte(8'h1B, ak);
    doStart; txByte(8'h1F, ak);
    rxByte(rd, 1'b1); check("R8 1B unchanged", rd, 8'h41);
    rxByte(rd, 1'b1); check("R9 1C reads zero", rd, 8'h00);
    rxByte(rd, 1'b0); check("R8 1D unchanged", rd, 8'h11);
    doStop; waitN(10);
    check("R9 read strobes", rdCount - rdBase, 2);

    // reserved write in burst is dropped, pointer advances
    expWr(8'h1F, 8'h5E); expWr(8'h21, 8'h07);
    doStart; txByte(8'h1E, ak); txByte(8'h1F, ak);
    txByte(8'h5E, ak); txByte(8'hA0, ak);
    check("R9 reserved write ack", ak, 2'b00);
    txByte(8'h07, ak);
    doStop; waitN(10);
    check("R9 burst writes", expQ.size(), 0);

    // stop in mid-byte, then normal transfer
    doStart;
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    doStop; waitN(10);
    check("R2 idle after stop", sdaOe, 0);
    doStart; txByte(8'h1E, ak); check("R2 addr after stop", ak, 2'b00);
    txByte(8'h06, ak);
    doStart; txByte(8'h1F, ak);
    rxByte(rd, 1'b0); check("R2 R6 rd 06", rd, 8'h5C);
    doStop; waitN(10);

    check("R5 queue empty", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule